// File: doc/BRIEF.md
# Seconds Counter with Alarm and Slow-Clock Prescaler

This block keeps time in a chip's always-on domain. A slow clock (typically a 32 kHz oscillator) enters on its own pin. It is synchronised into the bus clock, and its rising edges are divided by a programmable 16-bit prescaler. Every time the divider completes a period, a free-running 32-bit counter advances by one. When the prescaler equals the slow-clock rate, the counter counts seconds. Software cannot load the counter. It can only restart the counter from zero, and a restart also loads a new prescaler value.

Two events are recorded in a status word: "the counter just advanced" and "the counter just reached the alarm value". Both status bits clear when software reads the status word, and each can drive the single interrupt line through its own enable bit. The alarm register comes out of reset as all ones, which software treats as "no alarm armed".

The register bus is a plain single-cycle interface with no back-pressure. A write completes in the cycle that `bus_wr_en` is high. Read data appears on `bus_rd_data` one clock after `bus_rd_en`, and it holds until the next read. The interface has no ready or valid handshake, because every access is always accepted.

Top module: `slowtick_timer`

## Requirements
- R1: After reset, the mode word reads 0, the alarm word reads 0xFFFFFFFF, the counter reads 0, the status reads 0 and `irq_out` is low.
- R2: The mode word is at offset 0x00 and the alarm word is at 0x04. The counter is at 0x08 and the status word is at 0x0C. In the mode word, bits 15:0 are the prescaler, bit 16 is the alarm interrupt enable, bit 17 is the advance interrupt enable and bit 18 is the restart command. Bit 18 always reads 0, and reading any other offset returns 0.
- R3: A mode write with bit 18 set clears the counter and the divider, and loads the written prescaler as the active rate. A mode write with bit 18 clear changes the readback only, not the count rate.
- R4: With active prescaler P, the counter advances once every P rising slow-clock edges. A prescaler of 0 acts as 65536.
- R5: Writes to offset 0x08 leave the counter unchanged.
- R6: Status bit 1 is set on every counter advance.
- R7: Status bit 0 is set when the counter advances to a value equal to the alarm word.
- R8: A status read returns the current bits and then clears them. An event that arrives in the same cycle as the read stays set.
- R9: `irq_out` is high exactly when some status bit n is set and mode bit 16+n is set.
- R10: Read data is valid on the clock after `bus_rd_en` and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wr_en | input | 1 | Write strobe |
| bus_wr_data | input | 32 | Write data |
| bus_rd_en | input | 1 | Read strobe |
| bus_rd_data | output | 32 | Registered read data |
| slow_clk_in | input | 1 | Asynchronous slow clock |
| irq_out | output | 1 | Level interrupt |

## Verification
The bench times a slow-clock edge so that the counter advance lands in the same cycle as a status read. A design that lets the clear win would lose that advance event, and the following read would return zero. It runs the full 65536-edge period that a zero prescaler selects, which catches a design that divides by 0 or by 1 instead. It writes a new prescaler without a restart and checks that the old rate continues; a design that applies the value at once would show a different count. Randomised rounds vary the prescaler, the number of edges and the alarm position, and every round checks the count, both status bits and the interrupt line.

// File: rtl/slowtick_pkg.sv
package slowtick_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned PRES_W   = 16;
  localparam int unsigned OFF_MODE = 'h00;
  localparam int unsigned OFF_ALRM = 'h04;
  localparam int unsigned OFF_CNT  = 'h08;
  localparam int unsigned OFF_STS  = 'h0C;
  localparam int unsigned STS_ALM  = 0;
  localparam int unsigned STS_INC  = 1;
  localparam int unsigned EN_SHIFT = 16;
  localparam int unsigned RST_BIT  = 18;
  localparam logic [WORD_W-1:0] ALARM_IDLE = '1;

  typedef struct packed {
    logic inc;
    logic alm;
  } evt_t;
endpackage

// File: rtl/slowtick_sync_edge.sv
module slowtick_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_o
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sh_q[0] <= 1'b0;
          else        sh_q[0] <= async_in;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sh_q[g] <= 1'b0;
          else        sh_q[g] <= sh_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sh_q[STAGES-1];

  assign rise_o = sh_q[STAGES-1] & ~prev_q;

  assert_rise_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/slowtick_counter.sv
module slowtick_counter
  import slowtick_pkg::*;
#(
  parameter int unsigned CNT_W = WORD_W,
  parameter int unsigned DIV_W = PRES_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             restart_i,
  input  logic [DIV_W-1:0] load_pres_i,
  input  logic [CNT_W-1:0] alarm_i,
  output logic [CNT_W-1:0] count_o,
  output evt_t             evt_o
);
  logic [DIV_W-1:0] pres_q;
  logic [DIV_W-1:0] div_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nx;
  logic             wrap;

  // prescaler 0 wraps at 2^DIV_W-1, giving a 2^DIV_W period
  assign wrap   = tick_i && !restart_i && (div_q == pres_q - DIV_W'(1));
  assign cnt_nx = cnt_q + CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pres_q <= '0;
      div_q  <= '0;
      cnt_q  <= '0;
    end else if (restart_i) begin
      pres_q <= load_pres_i;
      div_q  <= '0;
      cnt_q  <= '0;
    end else if (tick_i) begin
      if (wrap) begin
        div_q <= '0;
        cnt_q <= cnt_nx;
      end else begin
        div_q <= div_q + DIV_W'(1);
      end
    end
  end

  assign count_o   = cnt_q;
  assign evt_o.inc = wrap;
  assign evt_o.alm = wrap && (cnt_nx == alarm_i);

  assert_restart_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (count_o == '0) && (div_q == '0));
  assert_step_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !restart_i |=> (count_o == $past(count_o)) || (count_o == $past(count_o) + CNT_W'(1)));
  assert_adv_counts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o.inc |=> count_o == $past(count_o) + CNT_W'(1));
  assert_alarm_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o.alm |=> count_o == $past(alarm_i));
endmodule

// File: rtl/slowtick_status.sv
module slowtick_status
  import slowtick_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  evt_t       evt_i,
  input  logic       clr_i,
  input  logic [1:0] en_i,
  output logic [1:0] sts_o,
  output logic       irq_o
);
  logic [1:0] sts_q;
  logic [1:0] set_v;

  always_comb begin
    set_v          = '0;
    set_v[STS_ALM] = evt_i.alm;
    set_v[STS_INC] = evt_i.inc;
  end

  genvar b;
  generate
    for (b = 0; b < 2; b++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)          sts_q[b] <= 1'b0;
        else if (set_v[b])   sts_q[b] <= 1'b1;
        else if (clr_i)      sts_q[b] <= 1'b0;
    end
  endgenerate

  assign sts_o = sts_q;
  assign irq_o = |(sts_q & en_i);

  assert_inc_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i.inc |=> sts_o[STS_INC]);
  assert_alm_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i.alm |=> sts_o[STS_ALM]);
  assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !evt_i.inc && !evt_i.alm) |=> sts_o == 2'b00);
endmodule

// File: rtl/slowtick_regbank.sv
module slowtick_regbank
  import slowtick_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  output logic [WORD_W-1:0] rd_data_o,
  input  logic [WORD_W-1:0] count_i,
  input  logic [1:0]        sts_i,
  output logic [PRES_W-1:0] load_pres_o,
  output logic              restart_o,
  output logic [1:0]        en_o,
  output logic [WORD_W-1:0] alarm_o,
  output logic              sts_clr_o
);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(OFF_MODE);
  localparam logic [ADDR_W-1:0] A_ALRM = ADDR_W'(OFF_ALRM);
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(OFF_CNT);
  localparam logic [ADDR_W-1:0] A_STS  = ADDR_W'(OFF_STS);

  logic [PRES_W-1:0] pres_q;
  logic [1:0]        en_q;
  logic [WORD_W-1:0] alarm_q;
  logic [WORD_W-1:0] rd_q;
  logic [WORD_W-1:0] rd_mux;
  logic              wr_mode;

  assign wr_mode = wr_en_i && (addr_i == A_MODE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pres_q  <= '0;
      en_q    <= '0;
      alarm_q <= ALARM_IDLE;
    end else if (wr_en_i) begin
      if (addr_i == A_MODE) begin
        pres_q <= wr_data_i[PRES_W-1:0];
        en_q   <= wr_data_i[EN_SHIFT+1:EN_SHIFT];
      end
      if (addr_i == A_ALRM) alarm_q <= wr_data_i;
    end
  end

  always_comb begin
    rd_mux = '0;
    unique case (addr_i)
      A_MODE:  rd_mux = {{(WORD_W-EN_SHIFT-2){1'b0}}, en_q, pres_q};
      A_ALRM:  rd_mux = alarm_q;
      A_CNT:   rd_mux = count_i;
      A_STS:   rd_mux = {{(WORD_W-2){1'b0}}, sts_i};
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       rd_q <= '0;
    else if (rd_en_i) rd_q <= rd_mux;

  assign rd_data_o   = rd_q;
  assign restart_o   = wr_mode && wr_data_i[RST_BIT];
  assign load_pres_o = wr_data_i[PRES_W-1:0];
  assign en_o        = en_q;
  assign alarm_o     = alarm_q;
  assign sts_clr_o   = rd_en_i && (addr_i == A_STS);

  assert_restart_reads_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && addr_i == A_MODE) |=> !rd_data_o[RST_BIT]);
  assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> $stable(rd_data_o));
endmodule

// File: rtl/slowtick_timer.sv
module slowtick_timer
  import slowtick_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr_en,
  input  logic [WORD_W-1:0] bus_wr_data,
  input  logic              bus_rd_en,
  output logic [WORD_W-1:0] bus_rd_data,
  input  logic              slow_clk_in,
  output logic              irq_out
);
  logic              tick;
  logic              restart;
  logic [PRES_W-1:0] load_pres;
  logic [1:0]        en;
  logic [WORD_W-1:0] alarm;
  logic [WORD_W-1:0] count;
  logic [1:0]        sts;
  logic              sts_clr;
  evt_t              evt;

  slowtick_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(slow_clk_in), .rise_o(tick));

  slowtick_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .restart_i(restart),
    .load_pres_i(load_pres), .alarm_i(alarm), .count_o(count), .evt_o(evt));

  slowtick_status u_sts (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .clr_i(sts_clr), .en_i(en),
    .sts_o(sts), .irq_o(irq_out));

  slowtick_regbank #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr_i(bus_addr), .wr_en_i(bus_wr_en),
    .wr_data_i(bus_wr_data), .rd_en_i(bus_rd_en), .rd_data_o(bus_rd_data),
    .count_i(count), .sts_i(sts), .load_pres_o(load_pres), .restart_o(restart),
    .en_o(en), .alarm_o(alarm), .sts_clr_o(sts_clr));

  assert_irq_needs_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (|sts));
  assert_irq_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (|en));
endmodule

// File: tb/test_slowtick_timer.sv
module test_slowtick_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr_en = 1'b0;
  logic [31:0] bus_wr_data = '0;
  logic        bus_rd_en = 1'b0;
  logic [31:0] bus_rd_data;
  logic        slow_clk_in = 1'b0;
  logic        irq_out;

  int unsigned n_checks = 0;
  int unsigned n_errors = 0;
  int unsigned cycles = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  slowtick_timer i_slowtick_timer (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
    .bus_wr_data(bus_wr_data), .bus_rd_en(bus_rd_en), .bus_rd_data(bus_rd_data),
    .slow_clk_in(slow_clk_in), .irq_out(irq_out));

  function automatic logic [31:0] exp_count(int unsigned edges, int unsigned p);
    int unsigned per = (p == 0) ? 65536 : p;
    return 32'(edges / per);
  endfunction

  function automatic logic [31:0] exp_status(int unsigned edges, int unsigned p,
                                             int unsigned alm);
    logic [31:0] c = exp_count(edges, p);
    logic [31:0] s = '0;
    s[1] = (c != 0);
    s[0] = (alm >= 1) && (alm <= c);
    return s;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr_data = d; bus_wr_en = 1'b1;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd_en = 1'b1;
    @(negedge clk);
    bus_rd_en = 1'b0;
    d = bus_rd_data;
  endtask

  task automatic pulses(input int unsigned n);
    for (int unsigned i = 0; i < n; i++) begin
      @(negedge clk) slow_clk_in = 1'b1;
      @(negedge clk) slow_clk_in = 1'b0;
    end
    repeat (5) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000 && !done) begin
      done = 1'b1;
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual=%0d expected<190000 cycles", cycles);
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int unsigned seed;
    seed = $urandom(32'h1357);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", {31'd0, irq_out}, 32'd0);
    bus_read(8'h00, d); check("R1 mode", d, 32'd0);
    bus_read(8'h04, d); check("R1 alarm", d, 32'hFFFF_FFFF);
    bus_read(8'h08, d); check("R1 count", d, 32'd0);
    bus_read(8'h0C, d); check("R1 status", d, 32'd0);

    // R2 restart bit reads zero, fields at 15:0 / 16 / 17
    bus_write(8'h00, 32'h0007_0003);
    bus_read(8'h00, d); check("R2 mode readback", d, 32'h0003_0003);
    bus_write(8'h00, 32'h0004_0003);
    bus_read(8'h10, d); check("R2 unmapped", d, 32'd0);
    bus_read(8'h0C, d);
    // R10 data holds after the read
    repeat (3) @(negedge clk);
    check("R10 hold", bus_rd_data, d);

    // R3 restart clears, R4 rate 3
    pulses(7);
    bus_read(8'h08, d); check("R4 rate 3", d, exp_count(7, 3));
    bus_write(8'h00, 32'h0004_0002);
    bus_read(8'h08, d); check("R3 restart clears", d, 32'd0);
    bus_write(8'h00, 32'h0000_0005);
    pulses(4);
    bus_read(8'h08, d); check("R3 no restart keeps rate", d, 32'd2);
    bus_read(8'h00, d); check("R3 readback new pres", d, 32'h0000_0005);

    // R5 counter is read-only
    bus_write(8'h08, 32'h0000_1234);
    bus_read(8'h08, d); check("R5 count write ignored", d, 32'd2);

    // R8 read clears, second read zero
    bus_read(8'h0C, d); check("R8 status before clear", d, 32'd2);
    bus_read(8'h0C, d); check("R8 status after clear", d, 32'd0);

    // R8 same-cycle event vs clear
    bus_write(8'h00, 32'h0004_0001);
    bus_read(8'h0C, d);
    @(negedge clk) slow_clk_in = 1'b1;
    @(negedge clk) slow_clk_in = 1'b0;
    @(negedge clk) begin bus_addr = 8'h0C; bus_rd_en = 1'b1; end
    @(negedge clk) bus_rd_en = 1'b0;
    check("R8 read before event", bus_rd_data, 32'd0);
    bus_read(8'h0C, d); check("R8 event kept over clear", d, 32'd2);

    // R7/R9 alarm interrupt
    bus_write(8'h04, 32'd2);
    bus_write(8'h00, 32'h0005_0001);
    bus_read(8'h0C, d);
    pulses(1);
    check("R9 no alarm yet", {31'd0, irq_out}, 32'd0);
    pulses(1);
    check("R9 alarm irq", {31'd0, irq_out}, 32'd1);
    bus_read(8'h0C, d); check("R7 alarm status", d, 32'd3);
    check("R9 irq drops after read", {31'd0, irq_out}, 32'd0);
    bus_write(8'h00, 32'h0002_0001);
    pulses(1);
    check("R9 advance irq", {31'd0, irq_out}, 32'd1);
    bus_write(8'h00, 32'h0000_0001);
    check("R9 disabled irq", {31'd0, irq_out}, 32'd0);
    bus_read(8'h0C, d); check("R6 advance status only", d, 32'd2);

    // random rounds: R4 R6 R7
    for (int r = 0; r < 14; r++) begin
      int unsigned p = 1 + ($urandom % 5);
      int unsigned n = $urandom % 21;
      int unsigned a = 1 + ($urandom % 6);
      bus_write(8'h04, 32'(a));
      bus_write(8'h00, 32'h0004_0000 | 32'(p));
      bus_read(8'h0C, d);
      pulses(n);
      bus_read(8'h08, d); check("R4 random count", d, exp_count(n, p));
      check("R9 random irq off", {31'd0, irq_out}, 32'd0);
      bus_read(8'h0C, d); check("R6 R7 random status", d, exp_status(n, p, a));
    end

    // R4 prescaler 0 means 65536
    bus_write(8'h04, 32'hFFFF_FFFF);
    bus_write(8'h00, 32'h0004_0000);
    pulses(65535);
    bus_read(8'h08, d); check("R4 pres0 before wrap", d, 32'd0);
    pulses(1);
    bus_read(8'h08, d); check("R4 pres0 wrap", d, 32'd1);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule